// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Bank

This block holds a bank of output cells for a programmable logic array. Each cell takes one OR sum from the array and an output-enable product term. It produces the value and enable for one I/O pad and a feedback signal back into the array. A four-bit code per cell selects three things: whether the pad sees the sum directly or through a D flip-flop, whether the output is active-high or active-low, and whether the feedback comes from the flip-flop, from the raw sum or from the pad input. The last choice lets the pad act as an input.

All cells share one preset product term, one clear product term and one clock. The preset acts at the clock edge. The clear acts at once and overrides the preset. A shared clock selector picks either the clock pin or a clock product term, in true or inverted form. The array and the electrical pad sit outside this block.

Top module: `plmc_bank`

## Requirements
- R1: Each cell's code `cfg[4*i+3 : 4*i]` is decoded as follows. Bit 0 is the polarity (1 = active-high). Bit 1 is the output type (0 = registered, 1 = combinational). Bits 3:2 are the feedback source: 00 = pad input, 01 = flip-flop, 11 = OR sum, 10 = undefined. This gives twelve defined codes.
- R2: In combinational mode, `pin_drv` equals the sum when active-high and its complement when active-low, with no clock edge needed.
- R3: In registered mode the flip-flop loads the sum on a rising edge of the selected clock. `pin_drv` is Q when active-high and the complement of Q when active-low.
- R4: `clk_sel[0]` picks the clock source: 0 = `clk_pin`, 1 = `clk_term`. `clk_sel[1]` = 1 inverts the chosen source, so loading happens on that source's falling edge. Edges on the source that is not selected have no effect.
- R5: A preset term that is true at a clock edge loads 1 into every cell's flip-flop, whatever the sum.
- R6: A true clear term forces every flip-flop to 0 at once, without a clock edge.
- R7: When clear and preset are both true, the flip-flops stay at 0.
- R8: `pin_oe` follows each cell's output-enable term. A term that is always true makes the pad a pure output, and one that is always false makes it a pure input.
- R9: `fb` carries the pad input, Q, or the sum, according to bits 3:2 of the cell's code.
- R10: A code with bits 3:2 = 10 behaves as combinational active-high output with pad feedback. Bits 1:0 are then ignored.
- R11: While `rst_n` is low, all flip-flops are held at 0.
- R12: Each cell follows only its own code, sum, enable and pad input. Preset, clear and clock are shared by all cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low, clears all flip-flops |
| clk_pin | input | 1 | Clock from the dedicated clock pin |
| clk_term | input | 1 | Clock from a product term |
| clk_sel | input | 2 | Bit 0 selects the source, bit 1 inverts it |
| preset_term | input | 1 | Shared synchronous preset term |
| clear_term | input | 1 | Shared asynchronous clear term |
| cfg | input | 4*CELLS | Per-cell configuration codes |
| sum_term | input | CELLS | OR sum for each cell |
| oe_term | input | CELLS | Output-enable term for each cell |
| pin_in | input | CELLS | Value read back from each pad |
| pin_drv | output | CELLS | Value driven onto each pad |
| pin_oe | output | CELLS | Pad driver enable for each cell |
| fb | output | CELLS | Feedback into the array for each cell |

## Verification
Two events can fall in the same cycle: the clear term and a clock edge that carries an active preset. The bench provokes this in two ways. Random cycles raise both terms at the same edge, and a directed case holds both terms high across an edge. In both cases every registered cell must read 0 afterwards. A further directed case raises clear between edges and checks that Q drops before any edge arrives.

// File: rtl/plmc_pkg.sv
package plmc_pkg;

   localparam int CFG_W = 4;

   typedef enum logic [1:0] {
      FB_PAD  = 2'b00,
      FB_FLOP = 2'b01,
      FB_RSVD = 2'b10,
      FB_SUM  = 2'b11
   } fb_src_e;

   typedef struct packed {
      logic    act_high;
      logic    comb_out;
      fb_src_e fb_src;
   } cell_mode_t;

   // Reserved feedback codes fall back to combinational, active-high, pad feedback.
   function automatic cell_mode_t decode_cfg(input logic [CFG_W-1:0] code);
      cell_mode_t m;
      m.fb_src   = fb_src_e'(code[3:2]);
      m.act_high = code[0];
      m.comb_out = code[1];
      if (m.fb_src == FB_RSVD) begin
         m.fb_src   = FB_PAD;
         m.act_high = 1'b1;
         m.comb_out = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/plmc_clk_sel.sv
module plmc_clk_sel #(
   parameter bit CLK_MUX_EN = 1'b1,
   parameter int SEL_W      = 2
) (
   input  logic             clk_pin,
   input  logic             clk_term,
   input  logic [SEL_W-1:0] clk_sel,
   output logic             clk_o
);
   if (SEL_W != 2) begin : g_bad_sel
      $error("plmc_clk_sel: SEL_W must be 2");
   end

   if (CLK_MUX_EN) begin : g_mux
      logic src;
      assign src   = clk_sel[0] ? clk_term : clk_pin;
      assign clk_o = src ^ clk_sel[1];
   end else begin : g_fixed
      assign clk_o = clk_pin;
   end
endmodule

// File: rtl/plmc_cfg_decode.sv
module plmc_cfg_decode
   import plmc_pkg::*;
(
   input  logic [CFG_W-1:0] code_i,
   output cell_mode_t       mode_o
);
   assign mode_o = decode_cfg(code_i);
endmodule

// File: rtl/plmc_cell.sv
module plmc_cell
   import plmc_pkg::*;
(
   input  logic       clk,
   input  logic       aclr,
   input  logic       preset,
   input  logic       sum,
   input  logic       oe,
   input  logic       pin_in,
   input  cell_mode_t mode,
   output logic       pin_drv,
   output logic       pin_oe,
   output logic       fb
);
   logic q;
   logic out_val;

   always_ff @(posedge clk or posedge aclr) begin
      if (aclr)        q <= 1'b0;
      else if (preset) q <= 1'b1;
      else             q <= sum;
   end

   assign out_val = mode.comb_out ? sum : q;
   assign pin_drv = mode.act_high ? out_val : ~out_val;
   assign pin_oe  = oe;

   always_comb begin
      unique case (mode.fb_src)
         FB_FLOP: fb = q;
         FB_SUM:  fb = sum;
         default: fb = pin_in;
      endcase
   end
endmodule

// File: rtl/plmc_bank.sv
module plmc_bank
   import plmc_pkg::*;
#(
   parameter int CELLS      = 4,
   parameter bit CLK_MUX_EN = 1'b1
) (
   input  logic                   rst_n,
   input  logic                   clk_pin,
   input  logic                   clk_term,
   input  logic [1:0]             clk_sel,
   input  logic                   preset_term,
   input  logic                   clear_term,
   input  logic [CELLS*CFG_W-1:0] cfg,
   input  logic [CELLS-1:0]       sum_term,
   input  logic [CELLS-1:0]       oe_term,
   input  logic [CELLS-1:0]       pin_in,
   output logic [CELLS-1:0]       pin_drv,
   output logic [CELLS-1:0]       pin_oe,
   output logic [CELLS-1:0]       fb
);
   if (CELLS < 1 || CELLS > 64) begin : g_bad_cells
      $error("plmc_bank: CELLS must be 1..64");
   end

   logic cell_clk;
   logic aclr;

   assign aclr = clear_term | ~rst_n;

   plmc_clk_sel #(.CLK_MUX_EN(CLK_MUX_EN), .SEL_W(2)) u_clk (
      .clk_pin (clk_pin),
      .clk_term(clk_term),
      .clk_sel (clk_sel),
      .clk_o   (cell_clk)
   );

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      cell_mode_t mode;

      plmc_cfg_decode u_dec (
         .code_i(cfg[i*CFG_W +: CFG_W]),
         .mode_o(mode)
      );

      plmc_cell u_cell (
         .clk    (cell_clk),
         .aclr   (aclr),
         .preset (preset_term),
         .sum    (sum_term[i]),
         .oe     (oe_term[i]),
         .pin_in (pin_in[i]),
         .mode   (mode),
         .pin_drv(pin_drv[i]),
         .pin_oe (pin_oe[i]),
         .fb     (fb[i])
      );
   end
endmodule

// File: rtl/plmc_bank_chk.sv
module plmc_bank_chk #(
   parameter int CELLS = 4
) (
   input logic               rst_n,
   input logic               clk_pin,
   input logic [1:0]         clk_sel,
   input logic               preset_term,
   input logic               clear_term,
   input logic [CELLS*4-1:0] cfg,
   input logic [CELLS-1:0]   sum_term,
   input logic [CELLS-1:0]   pin_in,
   input logic [CELLS-1:0]   pin_drv,
   input logic [CELLS-1:0]   fb
);
   for (genvar i = 0; i < CELLS; i++) begin : g_chk
      logic [3:0] c;
      logic       rsvd, flop_fb, reg_out;
      assign c       = cfg[i*4 +: 4];
      assign rsvd    = (c[3:2] == 2'b10);
      assign flop_fb = (c[3:2] == 2'b01);
      assign reg_out = !rsvd && !c[1];

      assert_comb_polarity_R2: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (!rsvd && c[1]) |-> (pin_drv[i] == (c[0] ? sum_term[i] : ~sum_term[i])));

      assert_clear_immediate_R6: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (clear_term && reg_out) |-> (pin_drv[i] == ~c[0]));

      assert_clear_wins_R7: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (clear_term && preset_term && flop_fb) |-> (fb[i] == 1'b0));

      assert_preset_load_R5: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (preset_term && !clear_term && clk_sel == 2'b00) |=>
         (clear_term || clk_sel != 2'b00 || cfg[i*4+2 +: 2] != 2'b01 || fb[i]));

      assert_flop_feedback_R9: assert property (@(posedge clk_pin) disable iff (!rst_n)
         (flop_fb && !c[1]) |-> (fb[i] == (c[0] ? pin_drv[i] : ~pin_drv[i])));

      assert_reserved_code_R10: assert property (@(posedge clk_pin) disable iff (!rst_n)
         rsvd |-> (pin_drv[i] == sum_term[i] && fb[i] == pin_in[i]));
   end
endmodule

bind plmc_bank plmc_bank_chk #(.CELLS(CELLS)) u_chk (
   .rst_n      (rst_n),
   .clk_pin    (clk_pin),
   .clk_sel    (clk_sel),
   .preset_term(preset_term),
   .clear_term (clear_term),
   .cfg        (cfg),
   .sum_term   (sum_term),
   .pin_in     (pin_in),
   .pin_drv    (pin_drv),
   .fb         (fb)
);

// File: tb/sim_plmc_bank.sv
module sim_plmc_bank;
   localparam int N     = 4;
   localparam int CLK_P = 10;

   logic           rst_n = 1'b0;
   logic           clk_pin = 1'b0;
   logic           clk_term = 1'b0;
   logic [1:0]     clk_sel = 2'b00;
   logic           preset_term = 1'b0;
   logic           clear_term = 1'b0;
   logic [N*4-1:0] cfg = '0;
   logic [N-1:0]   sum_term = '0;
   logic [N-1:0]   oe_term = '0;
   logic [N-1:0]   pin_in = '0;
   logic [N-1:0]   pin_drv, pin_oe, fb;

   logic [N-1:0]   mq = '0;
   int             errors = 0;
   int             checks = 0;

   plmc_bank #(.CELLS(N)) u0 (.*);

   always #(CLK_P/2) clk_pin = ~clk_pin;

   function automatic logic exp_drv(input logic [3:0] c, input logic s, input logic q);
      logic ah, co, o;
      if (c[3:2] == 2'b10) begin ah = 1'b1; co = 1'b1; end
      else begin ah = c[0]; co = c[1]; end
      o = co ? s : q;
      return ah ? o : ~o;
   endfunction

   function automatic logic exp_fb(input logic [3:0] c, input logic s, input logic q, input logic p);
      case (c[3:2])
         2'b01:   return q;
         2'b11:   return s;
         default: return p;
      endcase
   endfunction

   task automatic check_all(input string ctx);
      for (int i = 0; i < N; i++) begin
         logic [3:0] c;
         logic ed, ef;
         string rq;
         c  = cfg[i*4 +: 4];
         ed = exp_drv(c, sum_term[i], mq[i]);
         ef = exp_fb(c, sum_term[i], mq[i], pin_in[i]);
         rq = (c[3:2] == 2'b10) ? "R10" : (c[1] ? "R2" : "R3");
         checks += 3;
         if (pin_drv[i] !== ed) begin
            errors++;
            $display("FAIL %s %s cell %0d pin_drv actual=%b expected=%b", rq, ctx, i, pin_drv[i], ed);
         end
         if (fb[i] !== ef) begin
            errors++;
            $display("FAIL R9 %s cell %0d fb actual=%b expected=%b", ctx, i, fb[i], ef);
         end
         if (pin_oe[i] !== oe_term[i]) begin
            errors++;
            $display("FAIL R8 %s cell %0d pin_oe actual=%b expected=%b", ctx, i, pin_oe[i], oe_term[i]);
         end
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired before the run completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h0C0FFEE5));

      // R11: reset holds flops low even with sum high and clock running
      cfg      = {N{4'b0101}};   // registered, active-high, flop feedback (R1)
      sum_term = '1;
      oe_term  = '1;
      repeat (3) @(posedge clk_pin);
      #(CLK_P/4);
      mq = '0;
      check_all("R11 reset");
      @(negedge clk_pin);
      rst_n = 1'b1;

      // R12 random: independent per-cell codes, shared preset/clear
      for (int k = 0; k < 400; k++) begin
         @(negedge clk_pin);
         r = $urandom; cfg = r[N*4-1:0];
         r = $urandom; sum_term = r[N-1:0]; oe_term = r[2*N-1:N]; pin_in = r[3*N-1:2*N];
         preset_term = ($urandom % 4) == 0;
         clear_term  = ($urandom % 8) == 0;
         #1;
         if (clear_term) mq = '0;
         check_all("R12 random pre-edge");
         @(posedge clk_pin);
         if (clear_term)       mq = '0;
         else if (preset_term) mq = '1;
         else                  mq = sum_term;
         #(CLK_P/4);
         check_all("R12 random post-edge");
      end

      // R6: clear between edges drops Q immediately
      @(negedge clk_pin);
      cfg = {N{4'b0101}}; preset_term = 1'b0; clear_term = 1'b0; sum_term = '1; oe_term = 4'b0110;
      @(posedge clk_pin); mq = '1;
      #(CLK_P/4);
      check_all("R3 load ones");
      clear_term = 1'b1;
      #1; mq = '0;
      check_all("R6 async clear");

      // R7: clear and preset together across an edge
      @(negedge clk_pin);
      preset_term = 1'b1;
      @(posedge clk_pin);
      #(CLK_P/4);
      check_all("R7 clear beats preset");

      // R5: preset overrides a zero sum; mixed polarities
      @(negedge clk_pin);
      clear_term = 1'b0; sum_term = '0; cfg = {4'b0100, 4'b0101, 4'b0100, 4'b0101};
      @(posedge clk_pin); mq = '1;
      #(CLK_P/4);
      check_all("R5 preset");

      // R10: reserved code ignores low bits
      @(negedge clk_pin);
      preset_term = 1'b0;
      cfg = {4'b1000, 4'b1011, 4'b1001, 4'b1010};
      sum_term = 4'b1010; pin_in = 4'b0110;
      #1;
      check_all("R10 reserved code");

      // R4: term clock, pin edges ignored
      @(negedge clk_pin);
      clear_term = 1'b1; clk_sel = 2'b01; clk_term = 1'b0;
      cfg = {N{4'b0101}}; sum_term = 4'b1011;
      #1; mq = '0;
      @(negedge clk_pin);
      clear_term = 1'b0;
      repeat (2) @(posedge clk_pin);
      #(CLK_P/4);
      check_all("R4 pin edges ignored");
      clk_term = 1'b1;
      #1; mq = sum_term;
      check_all("R4 term rising");

      // R4: inverted term clock
      clear_term = 1'b1; clk_sel = 2'b11;
      #1; mq = '0;
      clear_term = 1'b0; sum_term = 4'b0110;
      #1;
      check_all("R4 inverted term idle");
      clk_term = 1'b0;
      #1; mq = sum_term;
      check_all("R4 inverted term falling");

      // R4: inverted pin clock loads on falling clk_pin
      @(posedge clk_pin);
      clear_term = 1'b1; clk_sel = 2'b10;
      #1; mq = '0;
      clear_term = 1'b0; sum_term = 4'b1001;
      #1;
      check_all("R4 inverted pin before fall");
      @(negedge clk_pin);
      #1; mq = sum_term;
      check_all("R4 inverted pin after fall");

      @(posedge clk_pin);
      #1;
      clear_term = 1'b1; clk_sel = 2'b00;
      @(negedge clk_pin);
      clear_term = 1'b0;
      repeat (2) @(posedge clk_pin);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule